// File: doc/BRIEF.md
# Serial Audio Justification Converter

This block translates a two-channel serial audio stream between the I2S layout and the right-justified layout. In both layouts the sample bits are sent MSB first, with the same word length and the same bit order. The two layouts differ in only two ways. The first is the level of the word clock that marks the left channel. The second is the bit slot, counted from the word-clock edge, in which the most significant bit appears. The block never rebuilds samples. It moves one of the two lines through a fixed shift register clocked by the bit clock, and it inverts the word clock.

The design has one clock domain. The serial bit clock is the clock, and every register updates on its falling edge. The receiver downstream can therefore sample on the rising edge with half a bit period of margin. A static select input chooses the direction of conversion. Changing the direction needs a reset in between. The bit clock is also driven back out unchanged, so the downstream receiver gets the clock that matches the converted lines.

The delay is D = SLOT_BITS − SAMPLE_BITS − 1 bit periods. With 24 slots per channel and 16-bit samples, D is 7.

Top module: `audio_justify_conv`

## Requirements
- R1: `bclk_out` equals `bclk` at all times.
- R2: Reset is synchronous and active low, and it is sampled on the falling edge of `bclk`. After any falling edge where `rst_n` is low, `wclk_out` and `sdata_out` are both 0.
- R3: With `dir_sel` = 0 (I2S in, right-justified out), `sdata_out` after falling edge n equals `sdata_in` as sampled on falling edge n−1−D.
- R4: With `dir_sel` = 0, `wclk_out` after falling edge n is the inverse of `wclk_in` as sampled on falling edge n−1.
- R5: With `dir_sel` = 1 (right-justified in, I2S out), `wclk_out` after falling edge n is the inverse of `wclk_in` as sampled on falling edge n−1−D.
- R6: With `dir_sel` = 1, `sdata_out` after falling edge n equals `sdata_in` as sampled on falling edge n−1.
- R7: Edges after reset are numbered from 0. On the first D+1 of them, the delayed path reads the zeros loaded during reset. So after edges 0..D, `sdata_out` is 0 when `dir_sel` = 0, and `wclk_out` is 1 when `dir_sel` = 1.
- R8: An I2S stream converts into a correct right-justified stream, and a right-justified stream converts into a correct I2S stream. In the I2S stream, the word clock is low for the left channel and the MSB sits one slot after the word-clock edge. In the right-justified stream, the word clock is high for the left channel and the LSB sits in the last slot of the channel. This holds for full-scale positive and full-scale negative samples.
- R9: `dir_sel` stays constant between resets. A direction change made with a reset in between gives a correct stream in the new direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Serial bit clock; all registers update on its falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_sel | input | 1 | 0: I2S to right-justified; 1: right-justified to I2S |
| wclk_in | input | 1 | Incoming word clock |
| sdata_in | input | 1 | Incoming serial data |
| bclk_out | output | 1 | Bit clock forwarded unchanged |
| wclk_out | output | 1 | Converted word clock, inverted and possibly delayed |
| sdata_out | output | 1 | Converted serial data, possibly delayed |

## Verification
The bench targets the off-by-one in the delay. A shift register that is one stage short or one stage long leaves the MSB in slot 7 or slot 9 of the right-justified channel, and the frame comparison catches it on the first nonzero sample. Full-scale positive and negative samples (0x7FFF, 0x8000) make sure a misplaced MSB or LSB shows up as a wrong bit rather than blending into similar neighbouring bits. The bench also checks the startup window, where a delay line that was not cleared would leak stale data or a stale word-clock level. It checks the reset that separates the two directions, where a design that routed the delay to the wrong line would swap which signal lags.

// File: rtl/ajc_pkg.sv
// Shared types and derived-constant helpers for the justification converter.
// Assumes: slot count per channel exceeds sample width by at least one.
package ajc_pkg;

    // Conversion direction chosen by the static select input.
    typedef enum logic {
        DIR_I2S_TO_RJ = 1'b0,
        DIR_RJ_TO_I2S = 1'b1
    } conv_dir_e;

    // Bit periods between the I2S MSB slot and the right-justified MSB slot.
    function automatic int unsigned realign_delay(int unsigned slot_bits,
                                                  int unsigned sample_bits);
        return slot_bits - sample_bits - 1;
    endfunction

endpackage

// File: rtl/ajc_capture.sv
// Input capture stage: registers the incoming serial lines on the falling
// bit-clock edge, mid-way through the sender's bit period.
// Assumes: the sender changes its lines on the rising edge.
module ajc_capture #(
    parameter int unsigned WIDTH = 2
) (
    input  logic             bclk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    // Sample all input lines; clear them during reset.
    always_ff @(negedge bclk) begin
        if (!rst_n) dout <= '0;
        else        dout <= din;
    end

endmodule

// File: rtl/ajc_delay_line.sv
// Fixed-length shift register on the falling bit-clock edge.
// Assumes: DEPTH may be zero, which gives a plain wire.
module ajc_delay_line #(
    parameter int unsigned DEPTH = 7
) (
    input  logic bclk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    generate
        if (DEPTH == 0) begin : g_wire
            assign dout = din;
        end else begin : g_shift
            logic [DEPTH-1:0] stage_q;

            // Shift one position per bit period; reset loads zeros.
            always_ff @(negedge bclk) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= (stage_q << 1) | DEPTH'(din);
            end

            assign dout = stage_q[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/ajc_route.sv
// Direction routing and output registers. It picks which captured line goes
// through the shared delay line, inverts the word clock, and registers both
// outputs on the falling edge.
// Assumes: dir is static between resets.
module ajc_route (
    input  logic             bclk,
    input  logic             rst_n,
    input  ajc_pkg::conv_dir_e dir,
    input  logic             cap_ws,
    input  logic             cap_dat,
    input  logic             dly_out,
    output logic             dly_in,
    output logic             ws_q,
    output logic             dat_q
);
    import ajc_pkg::*;

    logic ws_src;
    logic dat_src;

    // Select the delayed line for this direction and the undelayed partner.
    always_comb begin
        if (dir == DIR_RJ_TO_I2S) begin
            dly_in  = cap_ws;
            ws_src  = dly_out;
            dat_src = cap_dat;
        end else begin
            dly_in  = cap_dat;
            ws_src  = cap_ws;
            dat_src = dly_out;
        end
    end

    // Register outputs so they change only on the falling edge.
    always_ff @(negedge bclk) begin
        if (!rst_n) begin
            ws_q  <= 1'b0;
            dat_q <= 1'b0;
        end else begin
            ws_q  <= ~ws_src;
            dat_q <= dat_src;
        end
    end

endmodule

// File: rtl/audio_justify_conv.sv
// Top level: converts stereo serial audio between the I2S layout and the
// right-justified layout. It re-times one line through a fixed delay and
// inverts the word clock.
// Assumes: one bit-clock domain, static dir_sel, SLOT_BITS > SAMPLE_BITS.
module audio_justify_conv #(
    parameter int unsigned SAMPLE_BITS = 16,
    parameter int unsigned SLOT_BITS   = 24
) (
    input  logic bclk,
    input  logic rst_n,
    input  logic dir_sel,
    input  logic wclk_in,
    input  logic sdata_in,
    output logic bclk_out,
    output logic wclk_out,
    output logic sdata_out
);
    import ajc_pkg::*;

    localparam int unsigned DELAY  = realign_delay(SLOT_BITS, SAMPLE_BITS);
    localparam int unsigned WARM_W = $clog2(DELAY + 3) + 1;

    conv_dir_e  dir;
    logic [1:0] cap_q;
    logic       dly_in;
    logic       dly_out;

    assign dir      = conv_dir_e'(dir_sel);
    assign bclk_out = bclk;

    ajc_capture #(.WIDTH(2)) u_capture (
        .bclk (bclk),
        .rst_n(rst_n),
        .din  ({wclk_in, sdata_in}),
        .dout (cap_q)
    );

    ajc_delay_line #(.DEPTH(DELAY)) u_delay (
        .bclk (bclk),
        .rst_n(rst_n),
        .din  (dly_in),
        .dout (dly_out)
    );

    ajc_route u_route (
        .bclk   (bclk),
        .rst_n  (rst_n),
        .dir    (dir),
        .cap_ws (cap_q[1]),
        .cap_dat(cap_q[0]),
        .dly_out(dly_out),
        .dly_in (dly_in),
        .ws_q   (wclk_out),
        .dat_q  (sdata_out)
    );

    // Edges since reset, saturating; used only by the startup checks below.
    logic [WARM_W-1:0] warm_q;
    always_ff @(negedge bclk) begin
        if (!rst_n)                         warm_q <= '0;
        else if (warm_q != {WARM_W{1'b1}})  warm_q <= warm_q + 1'b1;
    end

    // R6: right-justified to I2S, data passes with only capture and output latency.
    a_r6_data_undelayed: assert property (@(negedge bclk) disable iff (!rst_n)
        (dir_sel && $past(rst_n) && $past(rst_n, 2)) |-> (sdata_out == $past(sdata_in, 2)));

    // R4: I2S to right-justified, word clock is inverted without added delay.
    a_r4_ws_inverted: assert property (@(negedge bclk) disable iff (!rst_n)
        (!dir_sel && $past(rst_n) && $past(rst_n, 2)) |-> (wclk_out == !$past(wclk_in, 2)));

    // R7: delayed data reads reset zeros during the startup window.
    a_r7_startup_data_zero: assert property (@(negedge bclk) disable iff (!rst_n)
        (!dir_sel && warm_q >= 1 && warm_q <= WARM_W'(DELAY + 1)) |-> (sdata_out == 1'b0));

    // R7: delayed word clock reads inverted reset zeros during startup.
    a_r7_startup_ws_high: assert property (@(negedge bclk) disable iff (!rst_n)
        (dir_sel && warm_q >= 1 && warm_q <= WARM_W'(DELAY + 1)) |-> (wclk_out == 1'b1));

    // R9: direction select held constant while out of reset.
    a_r9_dir_static: assert property (@(negedge bclk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(dir_sel));

endmodule

// File: tb/audio_justify_conv_tb.sv
module audio_justify_conv_tb;

    localparam int SB = 16;
    localparam int SL = 24;
    localparam int D  = SL - SB - 1;
    localparam int T  = 300;

    logic bclk = 1'b0;
    logic rst_n = 1'b0;
    logic dir_sel = 1'b0;
    logic wclk_in = 1'b0;
    logic sdata_in = 1'b0;
    logic bclk_out, wclk_out, sdata_out;

    int checks = 0;
    int failures = 0;
    logic win_h [0:T-1];
    logic din_h [0:T-1];
    logic [15:0] smp [0:7];

    audio_justify_conv #(.SAMPLE_BITS(SB), .SLOT_BITS(SL)) u_dut (
        .bclk(bclk), .rst_n(rst_n), .dir_sel(dir_sel),
        .wclk_in(wclk_in), .sdata_in(sdata_in),
        .bclk_out(bclk_out), .wclk_out(wclk_out), .sdata_out(sdata_out)
    );

    always #2 bclk = ~bclk;

    initial begin
        #(4 * 200000);
        failures++;
        checks++;
        $display("FAIL watchdog: got hung expected finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic chk(string req, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    // Ideal stream: edge_off shifts frame edges; i2s picks layout.
    task automatic gen(bit i2s, int edge_off, int t, output logic ws, output logic d);
        int u, ch, slot, first;
        logic [15:0] s;
        u = t - edge_off;
        if (u < 0) begin
            ws = 1'b0; d = 1'b0;
            return;
        end
        ch    = (u / SL) % 2;
        slot  = u % SL;
        s     = smp[(2 * (u / (2 * SL)) + ch) % 8];
        first = i2s ? 1 : (SL - SB);
        ws    = i2s ? ch[0] : ~ch[0];
        d     = (slot >= first && slot < first + SB) ? s[SB - 1 - (slot - first)] : 1'b0;
    endtask

    function automatic logic hist_ws(int i);
        return (i < 0) ? 1'b0 : win_h[i];
    endfunction

    function automatic logic hist_d(int i);
        return (i < 0) ? 1'b0 : din_h[i];
    endfunction

    task automatic run_dir(bit dir);
        logic ws, d, rws, rd;
        int n;
        rst_n = 1'b0;
        dir_sel = dir;
        wclk_in = 1'b1;
        sdata_in = 1'b1;
        repeat (2) @(negedge bclk);
        repeat (3) begin
            @(posedge bclk); #1;
            chk("R2 wclk_out in reset", wclk_out, 1'b0);
            chk("R2 sdata_out in reset", sdata_out, 1'b0);
        end
        for (int t = 0; t < T; t++) begin
            @(posedge bclk); #1;
            chk("R1 bclk_out high", bclk_out, 1'b1);
            if (t >= 1) begin
                n = t - 1;
                if (!dir) begin
                    chk(n <= D ? "R7 R3 dir0 data" : "R3 dir0 data", sdata_out, hist_d(n - 1 - D));
                    chk("R4 dir0 wclk", wclk_out, ~hist_ws(n - 1));
                end else begin
                    chk(n <= D ? "R7 R5 dir1 wclk" : "R5 dir1 wclk", wclk_out, ~hist_ws(n - 1 - D));
                    chk("R6 dir1 data", sdata_out, hist_d(n - 1));
                end
                if (n >= 32) begin
                    // R8 (and R9 for the second direction): compare against the ideal target stream.
                    gen(dir, dir ? D : 0, n - 1, rws, rd);
                    chk(dir ? "R8 R9 i2s wclk" : "R8 rj wclk", wclk_out, rws);
                    chk(dir ? "R8 R9 i2s data" : "R8 rj data", sdata_out, rd);
                end
            end
            gen(!dir, 0, t, ws, d);
            wclk_in = ws;
            sdata_in = d;
            win_h[t] = ws;
            din_h[t] = d;
            if (t == 0) rst_n = 1'b1;
            if (t % 50 == 7) begin
                @(negedge bclk); #1;
                chk("R1 bclk_out low", bclk_out, 1'b0);
            end
        end
    endtask

    initial begin
        smp[0] = 16'h7FFF; smp[1] = 16'h8000; smp[2] = 16'hA5C3; smp[3] = 16'h0001;
        smp[4] = 16'hFFFF; smp[5] = 16'h0000; smp[6] = 16'h8001; smp[7] = 16'h7FFE;
        run_dir(1'b0);
        run_dir(1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule